// File: doc/BRIEF.md
# Segmented Panorama Horizontal Scale Generator

This block supplies the per-double-pixel scale step for a horizontal resampler that sits after the frame store. It can apply a nonlinear "panorama" stretch. The centre of the picture keeps its geometry, and the sides are stretched more. To do this, the scale value ramps up or down under a separate signed slope in each of five segments of the output line.

A line begins with a `line_start` pulse. This reloads the running scale from the base control value and clears the phase. Each `step_en` then advances one double pixel. For that double pixel, the block reports four things: the scale value in use, the segment it falls in, how many whole input pixels the interpolator must advance, and the remaining 12-bit fractional phase. Four boundaries and the line length, all counted in double pixels, split the line into segments. Parameters are static while a line is running. Several control values can give the same effective factor, so no inverse mapping is assumed.

Top module: `pano_hscale_gen`

## Requirements
- R1: After reset, `out_valid` stays 0 for every `step_en` until the first `line_start`.
- R2: A `line_start` loads the running scale with `base_scale*8`, or with 8192 if `base_scale` is below 1024. It also clears the phase and the double-pixel counter. The first double pixel of the line reports that loaded scale.
- R3: A `step_en` with double-pixel counter n < `line_len` gives `out_valid`=1 on the next cycle, and the counter increments. Once n >= `line_len`, `step_en` gives no output. Without `step_en` there is never an output.
- R4: `seg_id` is the lowest i in 0..3 for which n < boundary i. Boundary i sits at `seg_bound[DPW*i +: DPW]`. If no such i exists, `seg_id` is 4. A segment with no double pixels, caused by non-monotonic or too-large boundaries, is skipped.
- R5: With `pano_en`=1, after each double pixel the running scale gains the signed 9-bit increment of that pixel's segment, `seg_inc[9*i +: 9]`, in units of 1/8. The double pixel that follows uses the new value.
- R6: With `pano_en`=0, every double pixel of the line reports the loaded base scale.
- R7: The running scale, reported in eighths on `scale_out`, saturates to the range 8192..32767 and never wraps.
- R8: For each double pixel, sum = phase + 2*floor(scale_out/8). `adv` = sum>>12 (0..2), and `phase` becomes sum mod 4096. `phase` is 0 straight after `line_start`.
- R9: If `line_start` and `step_en` arrive in the same cycle, `line_start` wins and no output is produced for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start of output line |
| step_en | input | 1 | Advance one double pixel |
| pano_en | input | 1 | Enable per-segment slopes |
| base_scale | input | 12 | Base control value, 1024..4095 |
| seg_inc | input | 45 | Five signed 9-bit increments in eighths, segment i at [9i+8:9i] |
| seg_bound | input | 4*DPW | Four segment end boundaries in double pixels |
| line_len | input | DPW | Line length in double pixels |
| out_valid | output | 1 | Result valid for one double pixel |
| seg_id | output | 3 | Segment of the reported double pixel |
| scale_out | output | 15 | Scale used, in eighths |
| adv | output | 2 | Whole input pixels to advance |
| phase | output | 12 | Fractional phase after the step |

## Verification
The bound checker enforces several properties on every cycle: the scale range stays saturated, `adv` never exceeds 2, `seg_id` stays legal, no output appears without a step, and a line restart blanks the output. The following depend on whole sequences of parameters and can only be shown by the bench scenarios comparing against a reference model:
- the piecewise ramp of the scale under each segment's slope;
- segment selection with unordered boundaries;
- the phase and carry arithmetic over a line;
- the end-of-line cutoff.

// File: rtl/pano_hscale_gen.sv
module pano_hscale_gen #(
  parameter int DPW  = 11,
  parameter int INCW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  logic                 step_en,
  input  logic                 pano_en,
  input  logic [11:0]          base_scale,
  input  logic [5*INCW-1:0]    seg_inc,
  input  logic [4*DPW-1:0]     seg_bound,
  input  logic [DPW-1:0]       line_len,
  output logic                 out_valid,
  output logic [2:0]           seg_id,
  output logic [14:0]          scale_out,
  output logic [1:0]           adv,
  output logic [11:0]          phase
);
  localparam int SW = 15;
  localparam logic signed [SW+1:0] SMIN = 17'sd8192;
  localparam logic signed [SW+1:0] SMAX = 17'sd32767;

  logic [DPW-1:0] cnt_q;
  logic [SW-1:0]  scl_q;
  logic [11:0]    ph_q;
  logic [2:0]     seg;

  always_comb begin
    seg = 3'd4;
    for (int i = 3; i >= 0; i--)
      if (cnt_q < seg_bound[i*DPW +: DPW]) seg = 3'(i);
  end

  logic signed [INCW-1:0] inc_sel;
  logic signed [SW+1:0]   raw;
  logic [SW-1:0]          scl_next, scl_load;
  logic [13:0]            sum;
  logic                   active;

  assign inc_sel  = $signed(seg_inc[seg*INCW +: INCW]);
  assign raw      = $signed({2'b00, scl_q}) + (pano_en ? (SW+2)'(inc_sel) : '0);
  assign scl_next = (raw < SMIN) ? SW'(SMIN) : (raw > SMAX) ? SW'(SMAX) : raw[SW-1:0];
  assign scl_load = (base_scale < 12'd1024) ? SW'(SMIN) : {base_scale, 3'b000};
  assign sum      = {2'b00, ph_q} + {1'b0, scl_q[SW-1:3], 1'b0};
  assign active   = step_en && (cnt_q < line_len);
  assign phase    = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      scl_q     <= SW'(SMIN);
      ph_q      <= '0;
      out_valid <= 1'b0;
      seg_id    <= '0;
      scale_out <= '0;
      adv       <= '0;
    end else begin
      out_valid <= 1'b0;
      if (line_start) begin
        cnt_q <= '0;
        scl_q <= scl_load;
        ph_q  <= '0;
      end else if (active) begin
        out_valid <= 1'b1;
        seg_id    <= seg;
        scale_out <= scl_q;
        adv       <= sum[13:12];
        ph_q      <= sum[11:0];
        scl_q     <= scl_next;
        cnt_q     <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module pano_hscale_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_start,
  input logic        step_en,
  input logic        out_valid,
  input logic [2:0]  seg_id,
  input logic [14:0] scale_out,
  input logic [1:0]  adv
);
  p_scale_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (scale_out >= 15'd8192));
  p_adv_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (adv != 2'd3));
  p_seg_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seg_id <= 3'd4));
  p_valid_needs_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> !out_valid);
  p_restart_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !out_valid);
endmodule

bind pano_hscale_gen pano_hscale_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .step_en(step_en),
  .out_valid(out_valid), .seg_id(seg_id), .scale_out(scale_out), .adv(adv)
);

// File: tb/test_pano_hscale_gen.sv
`timescale 1ns/1ps
module test_pano_hscale_gen;
  localparam int DPW = 11;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 1'b0, step_en = 1'b0, pano_en = 1'b0;
  logic [11:0] base_scale = 12'd2048;
  logic [44:0] seg_inc = '0;
  logic [4*DPW-1:0] seg_bound = '0;
  logic [DPW-1:0] line_len = '0;
  logic out_valid;
  logic [2:0] seg_id;
  logic [14:0] scale_out;
  logic [1:0] adv;
  logic [11:0] phase;

  pano_hscale_gen #(.DPW(DPW)) i_pano_hscale_gen (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int m_scale, m_cnt, m_phase;
  int incs[5];
  int bnds[4];
  bit started = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int seg_of(input int n);
    for (int i = 0; i < 4; i++) if (n < bnds[i]) return i;
    return 4;
  endfunction

  function automatic int sat(input int v);
    if (v < 8192) return 8192;
    if (v > 32767) return 32767;
    return v;
  endfunction

  task automatic apply(input int base, input bit pe, input int len);
    base_scale = 12'(base);
    pano_en = pe;
    line_len = DPW'(len);
    for (int i = 0; i < 5; i++) seg_inc[9*i +: 9] = 9'(incs[i]);
    for (int i = 0; i < 4; i++) seg_bound[DPW*i +: DPW] = DPW'(bnds[i]);
  endtask

  task automatic start_line(input bit with_step);
    line_start = 1'b1;
    step_en = with_step;
    @(posedge clk); @(negedge clk);
    line_start = 1'b0; step_en = 1'b0;
    chk(!out_valid, "R9 no output on line start", int'(out_valid), 0);
    m_scale = (base_scale < 1024) ? 8192 : int'(base_scale) * 8;
    m_cnt = 0; m_phase = 0; started = 1;
  endtask

  task automatic step(input bit st);
    bit ev;
    int es, eg, sum;
    ev = st && started && (m_cnt < int'(line_len));
    es = m_scale; eg = seg_of(m_cnt);
    sum = m_phase + 2 * (m_scale / 8);
    step_en = st;
    @(posedge clk); @(negedge clk);
    step_en = 1'b0;
    chk(out_valid == ev, started ? "R3 valid" : "R1 idle after reset", int'(out_valid), int'(ev));
    if (ev && out_valid) begin
      chk(int'(seg_id) == eg, "R4 segment", int'(seg_id), eg);
      chk(int'(scale_out) == es, pano_en ? "R5/R7 scale" : "R6 scale", int'(scale_out), es);
      chk(int'(adv) == sum / 4096, "R8 advance", int'(adv), sum / 4096);
      chk(int'(phase) == sum % 4096, "R8 phase", int'(phase), sum % 4096);
      m_phase = sum % 4096;
      m_scale = sat(m_scale + (pano_en ? incs[eg] : 0));
      m_cnt++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (incs[i]) incs[i] = 0;
    bnds = '{4, 8, 12, 16};
    apply(2048, 0, 20);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(!out_valid, "R1 reset state", int'(out_valid), 0);
    step(1); step(1);

    // R2/R6: base scale held, and a low base is clamped
    start_line(0);
    chk(phase == 0, "R8 phase cleared", int'(phase), 0);
    for (int k = 0; k < 22; k++) step(1);
    apply(500, 0, 6);
    start_line(0);
    step(1);
    chk(scale_out == 15'd8192, "R2 low base clamp", int'(scale_out), 8192);

    // R7: saturation upward and downward
    incs = '{255, 255, 255, 255, 255};
    apply(4095, 1, 30);
    start_line(0);
    for (int k = 0; k < 32; k++) step(1);
    incs = '{-256, -256, -256, -256, -256};
    apply(1024, 1, 30);
    start_line(0);
    for (int k = 0; k < 30; k++) step(1);

    // R4: unordered boundaries and boundaries past the end
    incs = '{8, -8, 16, -16, 24};
    bnds = '{10, 3, 6, 40};
    apply(3000, 1, 25);
    start_line(0);
    for (int k = 0; k < 26; k++) step(1);
    bnds = '{0, 0, 0, 0};
    apply(3000, 1, 5);
    start_line(0);
    for (int k = 0; k < 6; k++) step(1);

    // R9: restart with a simultaneous step, then a gap
    start_line(1);
    step(0); step(1);

    // random lines
    for (int ln = 0; ln < 60; ln++) begin
      foreach (incs[i]) incs[i] = int'($urandom % 512) - 256;
      foreach (bnds[i]) bnds[i] = int'($urandom % 70);
      if ($urandom % 2) bnds.sort();
      apply(1024 + int'($urandom % 3072), bit'($urandom % 4 != 0), 5 + int'($urandom % 60));
      start_line(0);
      for (int k = 0; k < int'(line_len) + 4; k++) step(bit'($urandom % 5 != 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule